// File: doc/BRIEF.md
# Floating-Point System Register Write Unit

This block executes the one instruction that copies a general-purpose register into a floating-point system register. Each cycle it looks at one instruction word with its valid flag. It also takes the result of the condition check, a flag that says the core runs at the unprivileged (user) level, a flag from the outer coprocessor access logic, and the value read from the register file for the source operand. When the word is this instruction, the block chooses one of four outcomes: a write to the status/control register, a write to the exception-control register, a silent drop (identification register), or an undefined-instruction pulse.

The status/control and exception-control registers live inside the block. Their values are always visible on read ports. A one-cycle write strobe and the written data are also brought out for the rest of the floating-point unit. Every encoding the architecture leaves unpredictable is resolved as undefined. Hypervisor trap routing and the access-control registers sit outside the block, and only the single access flag stands for them.

Top module: `fpsr_write_unit`

## Requirements
- R1: After reset, both the status/control and exception-control registers read zero, and neither undef_o nor any write strobe is asserted.
- R2: A word is this instruction only when bits[31:28] != 4'b1111, bits[27:20] == 8'hEE, bits[11:8] == 4'b1010 and bit[4] == 1. Any other word, or a word presented without instValid_i, changes no register and raises no undef_o.
- R3: When condPass_i is low, the instruction has no effect, even if its register field or operand is illegal.
- R4: Bits[19:16] select the target register: 0000 is identification, 0001 is status/control, 1000 is exception-control. Any other value raises undef_o for exactly one cycle, and nothing is written.
- R5: A source register field (bits[15:12]) equal to 15 raises undef_o, and nothing is written.
- R6: A nonzero value in bits[7:5] or bits[3:0] raises undef_o, and nothing is written.
- R7: A status/control write needs both fpAccess_i high and bit 30 (enable) of the exception-control register set. If either is missing, undef_o is raised and the register keeps its value.
- R8: An allowed status/control write loads srcData_i at the next clock edge, at any privilege level. statusWe_o pulses in the same cycle and wrData_o carries the value.
- R9: A write to the identification or exception-control register with userMode_i high raises undef_o.
- R10: A privileged exception-control write needs only fpAccess_i, whatever its own enable bit is. It loads srcData_i at the next edge and pulses excWe_o. Without access it raises undef_o.
- R11: A privileged write to the identification register raises no undef_o and changes neither stored register.
- R12: The 32-bit form with any condition other than 1111 decodes the same way as the paired-halfword form, whose top 12 bits are 1110_1110_1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid_i | input | 1 | Instruction word valid this cycle |
| instWord_i | input | 32 | Instruction word |
| condPass_i | input | 1 | Condition check result for the instruction |
| userMode_i | input | 1 | Core runs at the unprivileged level |
| fpAccess_i | input | 1 | Outer coprocessor access checks allow floating-point use |
| srcData_i | input | 32 | Value of the source general-purpose register |
| statusWe_o | output | 1 | One-cycle strobe: status/control register written |
| excWe_o | output | 1 | One-cycle strobe: exception-control register written |
| wrData_o | output | 32 | Data of the last write |
| undef_o | output | 1 | One-cycle undefined-instruction pulse |
| statusReg_o | output | 32 | Status/control register value |
| excReg_o | output | 32 | Exception-control register value |

## Verification
On every cycle the assertions check several things. A status/control write is only issued when access and the enable bit are both present. No exception-control write is issued in user mode. An undefined pulse never comes with a write. A failed condition never leads to a pulse. Each stored register changes only through its own strobe, and then to the sampled source value. Other behaviour is only shown by the bench's scenarios: the full sweep of unpredictable register codes, the should-be-zero and source-15 cases, the silent identification drop, the equivalence of the two encoding forms, and the enable bit taking effect through a previous exception-control write.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  parameter int DATA_W = 32;
  parameter int EN_BIT = 30;

  localparam logic [3:0] SEL_ID     = 4'b0000;
  localparam logic [3:0] SEL_STATUS = 4'b0001;
  localparam logic [3:0] SEL_EXC    = 4'b1000;

  localparam logic [7:0] OPC_MOVE   = 8'hEE;
  localparam logic [3:0] CP_FIELD   = 4'b1010;
  localparam logic [3:0] COND_NEVER = 4'b1111;
  localparam logic [3:0] RT_PC      = 4'hF;

  typedef struct packed {
    logic wrStatus;
    logic wrExc;
  } wrStrobe_t;

endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instValid_i,
  input  logic [31:0] instWord_i,
  input  logic        condPass_i,
  input  logic        userMode_i,
  input  logic        fpAccess_i,
  input  logic        excEn_i,
  output wrStrobe_t   strb_o,
  output logic        undef_o
);

  logic [3:0] condF, selF, rtF, cpF;
  logic [7:0] opF;
  logic [2:0] sbzHi;
  logic [3:0] sbzLo;
  logic       markBit;
  logic       isOurs, selKnown, badForm;
  logic       undefNext;
  logic       undefQ;

  always_comb begin
    condF   = instWord_i[31:28];
    opF     = instWord_i[27:20];
    selF    = instWord_i[19:16];
    rtF     = instWord_i[15:12];
    cpF     = instWord_i[11:8];
    sbzHi   = instWord_i[7:5];
    markBit = instWord_i[4];
    sbzLo   = instWord_i[3:0];
  end

  // Recognition: both encoding forms share one layout (paired form = cond 1110)
  assign isOurs = instValid_i && (condF != COND_NEVER) && (opF == OPC_MOVE)
                  && (cpF == CP_FIELD) && markBit;

  assign selKnown = (selF == SEL_ID) || (selF == SEL_STATUS) || (selF == SEL_EXC);
  assign badForm  = !selKnown || (rtF == RT_PC) || (sbzHi != 3'b000) || (sbzLo != 4'b0000);

  always_comb begin
    strb_o    = '0;
    undefNext = 1'b0;
    if (isOurs && condPass_i) begin
      if (badForm) begin
        undefNext = 1'b1;
      end else if (selF == SEL_STATUS) begin
        if (fpAccess_i && excEn_i) strb_o.wrStatus = 1'b1;
        else                       undefNext       = 1'b1;
      end else if (userMode_i) begin
        undefNext = 1'b1;
      end else if (!fpAccess_i) begin
        undefNext = 1'b1;
      end else if (selF == SEL_EXC) begin
        strb_o.wrExc = 1'b1;
      end
      // privileged identification write: accepted, dropped
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) undefQ <= 1'b0;
    else        undefQ <= undefNext;
  end

  assign undef_o = undefQ;

  // R7: status write strobe only with access and enable bit
  a_r7_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o.wrStatus |-> (fpAccess_i && excEn_i));

  // R9: no exception-control write in user mode
  a_r9_no_user_exc: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o.wrExc |-> !userMode_i);

  // R3: failed condition never produces an undefined pulse
  a_r3_condfail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid_i && !condPass_i) |=> !undef_o);

  // R2: no strobe without a valid instruction
  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid_i |-> (strb_o == '0));

endmodule

// File: rtl/fpsr_datapath.sv
module fpsr_datapath
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobe_t         strb_i,
  input  logic [DATA_W-1:0] srcData_i,
  input  logic              undef_i,
  output logic              excEn_o,
  output logic              statusWe_o,
  output logic              excWe_o,
  output logic [DATA_W-1:0] wrData_o,
  output logic [DATA_W-1:0] statusReg_o,
  output logic [DATA_W-1:0] excReg_o
);

  logic [DATA_W-1:0] statusQ, excQ, dataQ;
  logic              statusWeQ, excWeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ   <= '0;
      excQ      <= '0;
      dataQ     <= '0;
      statusWeQ <= 1'b0;
      excWeQ    <= 1'b0;
    end else begin
      statusWeQ <= strb_i.wrStatus;
      excWeQ    <= strb_i.wrExc;
      if (strb_i.wrStatus) statusQ <= srcData_i;
      if (strb_i.wrExc)    excQ    <= srcData_i;
      if (strb_i.wrStatus || strb_i.wrExc) dataQ <= srcData_i;
    end
  end

  assign excEn_o     = excQ[EN_BIT];
  assign statusWe_o  = statusWeQ;
  assign excWe_o     = excWeQ;
  assign wrData_o    = dataQ;
  assign statusReg_o = statusQ;
  assign excReg_o    = excQ;

  // R8: status register takes the sampled source value
  a_r8_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb_i.wrStatus |=> (statusQ == $past(srcData_i)));

  // R10: exception-control register takes the sampled source value
  a_r10_exc_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb_i.wrExc |=> (excQ == $past(srcData_i)));

  // R4: undefined pulse never coincides with a write strobe
  a_r4_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    undef_i |-> !(statusWeQ || excWeQ));

  // R11: registers only move through their own strobe
  a_r11_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_i.wrStatus |=> $stable(statusQ));
  a_r11_exc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_i.wrExc |=> $stable(excQ));

endmodule

// File: rtl/fpsr_write_unit.sv
module fpsr_write_unit
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid_i,
  input  logic [31:0]       instWord_i,
  input  logic              condPass_i,
  input  logic              userMode_i,
  input  logic              fpAccess_i,
  input  logic [DATA_W-1:0] srcData_i,
  output logic              statusWe_o,
  output logic              excWe_o,
  output logic [DATA_W-1:0] wrData_o,
  output logic              undef_o,
  output logic [DATA_W-1:0] statusReg_o,
  output logic [DATA_W-1:0] excReg_o
);

  wrStrobe_t strb;
  logic      excEn;
  logic      undefW;

  fpsr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instValid_i (instValid_i),
    .instWord_i  (instWord_i),
    .condPass_i  (condPass_i),
    .userMode_i  (userMode_i),
    .fpAccess_i  (fpAccess_i),
    .excEn_i     (excEn),
    .strb_o      (strb),
    .undef_o     (undefW)
  );

  fpsr_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_i      (strb),
    .srcData_i   (srcData_i),
    .undef_i     (undefW),
    .excEn_o     (excEn),
    .statusWe_o  (statusWe_o),
    .excWe_o     (excWe_o),
    .wrData_o    (wrData_o),
    .statusReg_o (statusReg_o),
    .excReg_o    (excReg_o)
  );

  assign undef_o = undefW;

endmodule

// File: tb/fpsr_write_unit_tb.sv
module fpsr_write_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        condPass = 1'b0;
  logic        userMode = 1'b0;
  logic        fpAccess = 1'b0;
  logic [31:0] srcData = '0;
  logic        statusWe, excWe, undef;
  logic [31:0] wrData, statusReg, excReg;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpsr_write_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instValid_i(instValid), .instWord_i(instWord),
    .condPass_i(condPass), .userMode_i(userMode), .fpAccess_i(fpAccess),
    .srcData_i(srcData), .statusWe_o(statusWe), .excWe_o(excWe),
    .wrData_o(wrData), .undef_o(undef), .statusReg_o(statusReg), .excReg_o(excReg)
  );

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] s, input logic [3:0] rt);
    return {c, 8'hEE, s, rt, 4'b1010, 3'b000, 1'b1, 4'b0000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one word for one cycle; returns at the negedge after the capturing edge
  task automatic issue(input logic [31:0] w, input logic cp, input logic u,
                       input logic a, input logic [31:0] d);
    @(negedge clk);
    instValid = 1'b1; instWord = w; condPass = cp; userMode = u;
    fpAccess = a; srcData = d;
    @(negedge clk);
    instValid = 1'b0; srcData = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    chk("R1 status", statusReg, 32'h0);
    chk("R1 exc", excReg, 32'h0);
    chk("R1 undef", {31'b0, undef}, 32'h0);
    chk("R1 strobes", {30'b0, statusWe, excWe}, 32'h0);
  endtask

  task automatic t_status_no_enable();
    issue(mk(4'hE, 4'b0001, 4'd2), 1, 0, 1, 32'h1111_1111);
    chk("R7 undef without enable", {31'b0, undef}, 32'h1);
    chk("R7 status kept", statusReg, 32'h0);
  endtask

  task automatic t_user_exc_id();
    issue(mk(4'hE, 4'b1000, 4'd3), 1, 1, 1, 32'h4000_0000);
    chk("R9 user exc undef", {31'b0, undef}, 32'h1);
    chk("R9 exc kept", excReg, 32'h0);
    issue(mk(4'hE, 4'b0000, 4'd3), 1, 1, 1, 32'h5);
    chk("R9 user id undef", {31'b0, undef}, 32'h1);
  endtask

  task automatic t_exc_write();
    issue(mk(4'hE, 4'b1000, 4'd4), 1, 0, 0, 32'h4000_0000);
    chk("R10 no access undef", {31'b0, undef}, 32'h1);
    chk("R10 exc kept", excReg, 32'h0);
    issue(mk(4'hE, 4'b1000, 4'd4), 1, 0, 1, 32'h4000_00A5);
    chk("R10 undef low", {31'b0, undef}, 32'h0);
    chk("R10 exc loaded", excReg, 32'h4000_00A5);
    chk("R10 excWe pulse", {31'b0, excWe}, 32'h1);
    chk("R10 wrData", wrData, 32'h4000_00A5);
    @(negedge clk);
    chk("R10 excWe single", {31'b0, excWe}, 32'h0);
  endtask

  task automatic t_status_write();
    issue(mk(4'hE, 4'b0001, 4'd5), 1, 0, 0, 32'h1234_5678);
    chk("R7 no access undef", {31'b0, undef}, 32'h1);
    chk("R7 status kept", statusReg, 32'h0);
    issue(mk(4'hE, 4'b0001, 4'd5), 1, 1, 1, 32'h1234_5678);
    chk("R8 undef low", {31'b0, undef}, 32'h0);
    chk("R8 status loaded", statusReg, 32'h1234_5678);
    chk("R8 statusWe pulse", {31'b0, statusWe}, 32'h1);
    chk("R8 wrData", wrData, 32'h1234_5678);
  endtask

  task automatic t_id_drop();
    issue(mk(4'hE, 4'b0000, 4'd6), 1, 0, 1, 32'hFFFF_FFFF);
    chk("R11 no undef", {31'b0, undef}, 32'h0);
    chk("R11 status same", statusReg, 32'h1234_5678);
    chk("R11 exc same", excReg, 32'h4000_00A5);
    chk("R11 no strobe", {30'b0, statusWe, excWe}, 32'h0);
  endtask

  task automatic t_unpredictable_sel();
    for (int s = 0; s < 16; s++) begin
      if (s == 0 || s == 1 || s == 8) continue;
      issue(mk(4'hE, 4'(s), 4'd1), 1, 0, 1, 32'h0BAD_0000 + s);
      chk($sformatf("R4 undef sel %0d", s), {31'b0, undef}, 32'h1);
      chk("R4 status same", statusReg, 32'h1234_5678);
      chk("R4 exc same", excReg, 32'h4000_00A5);
    end
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, undef}, 32'h0);
  endtask

  task automatic t_rt15();
    issue(mk(4'hE, 4'b0001, 4'hF), 1, 0, 1, 32'h7);
    chk("R5 rt15 undef", {31'b0, undef}, 32'h1);
    chk("R5 status same", statusReg, 32'h1234_5678);
  endtask

  task automatic t_sbz();
    issue(mk(4'hE, 4'b0001, 4'd2) | 32'h0000_0020, 1, 0, 1, 32'h8);
    chk("R6 bit5 undef", {31'b0, undef}, 32'h1);
    issue(mk(4'hE, 4'b1000, 4'd2) | 32'h0000_0001, 1, 0, 1, 32'h8);
    chk("R6 bit0 undef", {31'b0, undef}, 32'h1);
    chk("R6 status same", statusReg, 32'h1234_5678);
    chk("R6 exc same", excReg, 32'h4000_00A5);
  endtask

  task automatic t_condfail();
    issue(mk(4'hE, 4'b0110, 4'd2), 0, 0, 1, 32'h9);
    chk("R3 bad sel quiet", {31'b0, undef}, 32'h0);
    issue(mk(4'hE, 4'b0001, 4'd2), 0, 0, 1, 32'h9);
    chk("R3 status same", statusReg, 32'h1234_5678);
    chk("R3 no strobe", {31'b0, statusWe}, 32'h0);
  endtask

  task automatic t_not_ours();
    issue(mk(4'hE, 4'b0001, 4'd2) ^ 32'h0000_0100, 1, 0, 1, 32'hA);
    chk("R2 cp field", {31'b0, undef}, 32'h0);
    chk("R2 status same", statusReg, 32'h1234_5678);
    issue(mk(4'hF, 4'b0110, 4'd2), 1, 0, 1, 32'hA);
    chk("R2 cond 1111 quiet", {31'b0, undef}, 32'h0);
    issue(mk(4'hE, 4'b0001, 4'd2) & ~32'h0000_0010, 1, 0, 1, 32'hA);
    chk("R2 bit4 clear", statusReg, 32'h1234_5678);
    @(negedge clk);
    instWord = mk(4'hE, 4'b0001, 4'd2); condPass = 1; fpAccess = 1; srcData = 32'hB;
    @(negedge clk);
    chk("R2 invalid word ignored", statusReg, 32'h1234_5678);
  endtask

  task automatic t_forms();
    issue(32'hEEE1_2A10, 1, 0, 1, 32'hCAFE_0001);
    chk("R12 paired form", statusReg, 32'hCAFE_0001);
    issue(mk(4'h0, 4'b0001, 4'd7), 1, 0, 1, 32'hCAFE_0002);
    chk("R12 cond 0000", statusReg, 32'hCAFE_0002);
  endtask

  task automatic t_enable_cleared();
    issue(mk(4'hE, 4'b1000, 4'd1), 1, 0, 1, 32'h0000_0001);
    chk("R10 exc cleared", excReg, 32'h0000_0001);
    issue(mk(4'hE, 4'b0001, 4'd1), 1, 0, 1, 32'h3);
    chk("R7 undef after clear", {31'b0, undef}, 32'h1);
    chk("R7 status same", statusReg, 32'hCAFE_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_no_enable();
    t_user_exc_id();
    t_exc_write();
    t_status_write();
    t_id_drop();
    t_unpredictable_sel();
    t_rt15();
    t_sbz();
    t_condfail();
    t_not_ours();
    t_forms();
    t_enable_cleared();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule